// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block carries out the register transfers selected by the three 3-bit operation fields of a horizontal microinstruction. Each field is decoded on its own into one of eight fixed transfers, and transfers from different fields fire together on the same rising clock edge. The state is a 16-bit accumulator, a 16-bit data register, an 11-bit address register, an 11-bit program counter and a 2048-word by 16-bit main memory held inside the block.

An external microprogram sequencer drives the three field codes every cycle and reads back the status bits it branches on: the top bit of the data register, which is the indirect flag of a fetched instruction word; the accumulator sign; an accumulator-is-zero flag; and the four opcode bits of the fetched word, which the sequencer maps to a routine address. An instruction word keeps its indirect flag at bit 15, its opcode in bits 14..11 and its operand address in bits 10..0. A preload port lets a test environment fill the memory before the microcode runs.

Every update uses the values the registers held before the clock edge, so a single microinstruction can swap the accumulator and data register, or read memory while it advances the program counter. A legal microinstruction has at most one field that writes any given register.

Top module: `uacc_datapath`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator, data register, address register and program counter read zero.
- R2: Field 1 code 1 adds the data register into the accumulator, 2 clears the accumulator, 3 increments it, 4 copies the data register into it, 5 loads data register bits 10..0 into the address register, 6 loads the program counter into the address register, 7 writes the data register to memory at the address register; code 0 changes nothing.
- R3: Field 2 code 1 subtracts the data register from the accumulator, 2 ORs it in, 3 ANDs it in, 4 loads the memory word at the address register into the data register, 5 copies the accumulator into the data register, 6 increments the data register, 7 replaces data register bits 10..0 with the program counter and keeps bits 15..11; code 0 changes nothing.
- R4: Field 3 code 1 XORs the data register into the accumulator, 2 complements the accumulator, 3 shifts it left, 4 shifts it right, 5 increments the program counter, 6 copies the address register into the program counter; codes 0 and 7 change nothing.
- R5: Shifts bring in a zero at the vacated end, and accumulator, data register and program counter arithmetic wrap around with no carry kept.
- R6: Field 1 code 4 together with field 2 code 5 swaps the accumulator and the data register.
- R7: All transfers in one microinstruction use pre-edge values: a memory read together with a program counter increment does both, and a memory write together with a data register increment stores the old data register value.
- R8: The status outputs show data register bit 15, accumulator bit 15, a flag that is 1 exactly when the accumulator is zero, and data register bits 14..11.
- R9: While the preload enable is high the memory word at the preload address takes the preload data, and a field 1 write in that same cycle is ignored.
- R10: With all three fields at code 0 and no preload, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| f1Code | input | 3 | First microoperation field |
| f2Code | input | 3 | Second microoperation field |
| f3Code | input | 3 | Third microoperation field |
| preloadEn | input | 1 | Memory preload strobe |
| preloadAddr | input | 11 | Memory preload address |
| preloadData | input | 16 | Memory preload data |
| acOut | output | 16 | Accumulator |
| drOut | output | 16 | Data register |
| arOut | output | 11 | Address register |
| pcOut | output | 11 | Program counter |
| drTopBit | output | 1 | Data register bit 15 (indirect flag) |
| acSignBit | output | 1 | Accumulator bit 15 |
| acIsZero | output | 1 | Accumulator equals zero |
| drOpcode | output | 4 | Data register bits 14..11 |

## Verification
The assertions watch, on every cycle, that a swap exchanges the two old values, that a clear leaves a zero accumulator, that a left shift brings in a zero, that the program counter and address register take their sources, that a partial data register load keeps its upper bits, and that an all-zero microinstruction holds every register. Memory contents, the priority of preload over a field write, the pre-edge value a write stores, and the full arithmetic and logic results can only be shown by the bench's scenarios, which run fetch-like sequences, wrap cases and the combined field cases against a behavioural model.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

  typedef enum logic [3:0] {
    AC_HOLD, AC_ADD, AC_CLR, AC_INC, AC_FROM_DR, AC_SUB, AC_OR,
    AC_AND, AC_XOR, AC_COM, AC_SHL, AC_SHR
  } acSel_e;

  typedef enum logic [2:0] {
    DR_HOLD, DR_FROM_MEM, DR_FROM_AC, DR_INC, DR_LOW_FROM_PC
  } drSel_e;

  typedef enum logic [1:0] {
    AR_HOLD, AR_FROM_PC, AR_FROM_DR
  } arSel_e;

  typedef enum logic [1:0] {
    PC_HOLD, PC_INC, PC_FROM_AR
  } pcSel_e;

  typedef struct packed {
    acSel_e acSel;
    drSel_e drSel;
    arSel_e arSel;
    pcSel_e pcSel;
    logic   memWr;
  } strobes_t;

endpackage

// File: rtl/uacc_field_decode.sv
module uacc_field_decode
  import uacc_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic [FIELD_W-1:0] f1Code,
  input  logic [FIELD_W-1:0] f2Code,
  input  logic [FIELD_W-1:0] f3Code,
  input  logic               preloadEn,
  output strobes_t           strobes
);

  // Fields are decoded lowest priority first so that, for an illegal
  // microinstruction, field 1 overrides field 2 and field 2 overrides field 3.
  always_comb begin
    strobes = '0;

    case (f3Code)
      3'd1: strobes.acSel = AC_XOR;
      3'd2: strobes.acSel = AC_COM;
      3'd3: strobes.acSel = AC_SHL;
      3'd4: strobes.acSel = AC_SHR;
      3'd5: strobes.pcSel = PC_INC;
      3'd6: strobes.pcSel = PC_FROM_AR;
      default: ;
    endcase

    case (f2Code)
      3'd1: strobes.acSel = AC_SUB;
      3'd2: strobes.acSel = AC_OR;
      3'd3: strobes.acSel = AC_AND;
      3'd4: strobes.drSel = DR_FROM_MEM;
      3'd5: strobes.drSel = DR_FROM_AC;
      3'd6: strobes.drSel = DR_INC;
      3'd7: strobes.drSel = DR_LOW_FROM_PC;
      default: ;
    endcase

    case (f1Code)
      3'd1: strobes.acSel = AC_ADD;
      3'd2: strobes.acSel = AC_CLR;
      3'd3: strobes.acSel = AC_INC;
      3'd4: strobes.acSel = AC_FROM_DR;
      3'd5: strobes.arSel = AR_FROM_DR;
      3'd6: strobes.arSel = AR_FROM_PC;
      3'd7: strobes.memWr = !preloadEn;  // R9: preload wins the memory port
      default: ;
    endcase
  end

endmodule

// File: rtl/uacc_regs.sv
module uacc_regs
  import uacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strobes,
  input  logic              preloadEn,
  input  logic [ADDR_W-1:0] preloadAddr,
  input  logic [DATA_W-1:0] preloadData,
  output logic [DATA_W-1:0] acQ,
  output logic [DATA_W-1:0] drQ,
  output logic [ADDR_W-1:0] arQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic              drTopBit,
  output logic              acSignBit,
  output logic              acIsZero,
  output logic [OPC_W-1:0]  drOpcode
);

  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int OPC_LSB   = DATA_W - 1 - OPC_W;

  logic [DATA_W-1:0] memArr [MEM_DEPTH];
  logic [DATA_W-1:0] memRead;
  logic [DATA_W-1:0] acNext, drNext;
  logic [ADDR_W-1:0] arNext, pcNext;

  assign memRead = memArr[arQ];

  always_comb begin
    case (strobes.acSel)
      AC_ADD:     acNext = acQ + drQ;
      AC_CLR:     acNext = '0;
      AC_INC:     acNext = acQ + 1'b1;
      AC_FROM_DR: acNext = drQ;
      AC_SUB:     acNext = acQ - drQ;
      AC_OR:      acNext = acQ | drQ;
      AC_AND:     acNext = acQ & drQ;
      AC_XOR:     acNext = acQ ^ drQ;
      AC_COM:     acNext = ~acQ;
      AC_SHL:     acNext = {acQ[DATA_W-2:0], 1'b0};
      AC_SHR:     acNext = {1'b0, acQ[DATA_W-1:1]};
      default:    acNext = acQ;
    endcase
  end

  always_comb begin
    case (strobes.drSel)
      DR_FROM_MEM:    drNext = memRead;
      DR_FROM_AC:     drNext = acQ;
      DR_INC:         drNext = drQ + 1'b1;
      DR_LOW_FROM_PC: drNext = {drQ[DATA_W-1:ADDR_W], pcQ};
      default:        drNext = drQ;
    endcase
  end

  always_comb begin
    case (strobes.arSel)
      AR_FROM_PC: arNext = pcQ;
      AR_FROM_DR: arNext = drQ[ADDR_W-1:0];
      default:    arNext = arQ;
    endcase
  end

  always_comb begin
    case (strobes.pcSel)
      PC_INC:     pcNext = pcQ + 1'b1;
      PC_FROM_AR: pcNext = arQ;
      default:    pcNext = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acQ <= '0;
      drQ <= '0;
      arQ <= '0;
      pcQ <= '0;
    end else begin
      acQ <= acNext;
      drQ <= drNext;
      arQ <= arNext;
      pcQ <= pcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (preloadEn)
      memArr[preloadAddr] <= preloadData;
    else if (strobes.memWr)
      memArr[arQ] <= drQ;
  end

  assign drTopBit  = drQ[DATA_W-1];
  assign acSignBit = acQ[DATA_W-1];
  assign acIsZero  = (acQ == '0);
  assign drOpcode  = drQ[OPC_LSB +: OPC_W];

  assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.acSel == AC_FROM_DR && strobes.drSel == DR_FROM_AC)
      |=> (acQ == $past(drQ) && drQ == $past(acQ)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.acSel == AC_CLR) |=> (acQ == '0));

  assert_ar_from_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.arSel == AR_FROM_PC) |=> (arQ == $past(pcQ)));

  assert_shl_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.acSel == AC_SHL) |=> (acQ[0] == 1'b0));

  assert_pc_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.pcSel == PC_INC) |=> (pcQ == $past(pcQ) + 1'b1));

  assert_dr_low_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.drSel == DR_LOW_FROM_PC)
      |=> (drQ[DATA_W-1:ADDR_W] == $past(drQ[DATA_W-1:ADDR_W])
           && drQ[ADDR_W-1:0] == $past(pcQ)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes == '0) |=> ($stable(acQ) && $stable(drQ) && $stable(arQ) && $stable(pcQ)));

endmodule

// File: rtl/uacc_datapath.sv
module uacc_datapath
  import uacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 11,
  parameter int OPC_W   = 4,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] f1Code,
  input  logic [FIELD_W-1:0] f2Code,
  input  logic [FIELD_W-1:0] f3Code,
  input  logic               preloadEn,
  input  logic [ADDR_W-1:0]  preloadAddr,
  input  logic [DATA_W-1:0]  preloadData,
  output logic [DATA_W-1:0]  acOut,
  output logic [DATA_W-1:0]  drOut,
  output logic [ADDR_W-1:0]  arOut,
  output logic [ADDR_W-1:0]  pcOut,
  output logic               drTopBit,
  output logic               acSignBit,
  output logic               acIsZero,
  output logic [OPC_W-1:0]   drOpcode
);

  strobes_t strobes;

  uacc_field_decode #(.FIELD_W(FIELD_W)) i_decode (
    .f1Code    (f1Code),
    .f2Code    (f2Code),
    .f3Code    (f3Code),
    .preloadEn (preloadEn),
    .strobes   (strobes)
  );

  uacc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .preloadEn   (preloadEn),
    .preloadAddr (preloadAddr),
    .preloadData (preloadData),
    .acQ         (acOut),
    .drQ         (drOut),
    .arQ         (arOut),
    .pcQ         (pcOut),
    .drTopBit    (drTopBit),
    .acSignBit   (acSignBit),
    .acIsZero    (acIsZero),
    .drOpcode    (drOpcode)
  );

endmodule

// File: tb/test_uacc_datapath.sv
module test_uacc_datapath;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  f1Code = '0, f2Code = '0, f3Code = '0;
  logic        preloadEn = 1'b0;
  logic [10:0] preloadAddr = '0;
  logic [15:0] preloadData = '0;
  logic [15:0] acOut, drOut;
  logic [10:0] arOut, pcOut;
  logic        drTopBit, acSignBit, acIsZero;
  logic [3:0]  drOpcode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] mAc = '0, mDr = '0;
  logic [10:0] mAr = '0, mPc = '0;
  logic [15:0] mMem [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  uacc_datapath i_uacc_datapath (
    .clk(clk), .rst_n(rst_n), .f1Code(f1Code), .f2Code(f2Code), .f3Code(f3Code),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .acOut(acOut), .drOut(drOut), .arOut(arOut), .pcOut(pcOut),
    .drTopBit(drTopBit), .acSignBit(acSignBit), .acIsZero(acIsZero), .drOpcode(drOpcode)
  );

  task automatic check(string what, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check("ac", req, acOut, mAc);
    check("dr", req, drOut, mDr);
    check("ar", req, {5'd0, arOut}, {5'd0, mAr});
    check("pc", req, {5'd0, pcOut}, {5'd0, mPc});
    check("drTopBit R8", req, {15'd0, drTopBit}, {15'd0, mDr[15]});
    check("acSignBit R8", req, {15'd0, acSignBit}, {15'd0, mAc[15]});
    check("acIsZero R8", req, {15'd0, acIsZero}, {15'd0, (mAc == 16'd0)});
    check("drOpcode R8", req, {12'd0, drOpcode}, {12'd0, mDr[14:11]});
  endtask

  // Behavioural model of one microinstruction, all from pre-edge values.
  task automatic modelStep(logic [2:0] a1, logic [2:0] a2, logic [2:0] a3,
                           logic pe, logic [10:0] pa, logic [15:0] pd);
    logic [15:0] nAc = mAc, nDr = mDr;
    logic [10:0] nAr = mAr, nPc = mPc;
    if (a1 == 3'd1) nAc = mAc + mDr;
    if (a1 == 3'd2) nAc = 16'd0;
    if (a1 == 3'd3) nAc = mAc + 16'd1;
    if (a1 == 3'd4) nAc = mDr;
    if (a1 == 3'd5) nAr = mDr[10:0];
    if (a1 == 3'd6) nAr = mPc;
    if (a2 == 3'd1) nAc = mAc - mDr;
    if (a2 == 3'd2) nAc = mAc | mDr;
    if (a2 == 3'd3) nAc = mAc & mDr;
    if (a2 == 3'd4) nDr = mMem[mAr];
    if (a2 == 3'd5) nDr = mAc;
    if (a2 == 3'd6) nDr = mDr + 16'd1;
    if (a2 == 3'd7) nDr[10:0] = mPc;
    if (a3 == 3'd1) nAc = mAc ^ mDr;
    if (a3 == 3'd2) nAc = ~mAc;
    if (a3 == 3'd3) nAc = mAc << 1;
    if (a3 == 3'd4) nAc = mAc >> 1;
    if (a3 == 3'd5) nPc = mPc + 11'd1;
    if (a3 == 3'd6) nPc = mAr;
    if (pe) mMem[pa] = pd;
    else if (a1 == 3'd7) mMem[mAr] = mDr;
    mAc = nAc; mDr = nDr; mAr = nAr; mPc = nPc;
  endtask

  task automatic step(logic [2:0] a1, logic [2:0] a2, logic [2:0] a3,
                      logic pe, logic [10:0] pa, logic [15:0] pd, string req);
    f1Code = a1; f2Code = a2; f3Code = a3;
    preloadEn = pe; preloadAddr = pa; preloadData = pd;
    @(posedge clk);
    modelStep(a1, a2, a3, pe, pa, pd);
    @(negedge clk);
    f1Code = '0; f2Code = '0; f3Code = '0; preloadEn = 1'b0;
    compareAll(req);
  endtask

  task automatic uop(logic [2:0] a1, logic [2:0] a2, logic [2:0] a3, string req);
    step(a1, a2, a3, 1'b0, 11'd0, 16'd0, req);
  endtask

  task automatic preload(logic [10:0] pa, logic [15:0] pd);
    step(3'd0, 3'd0, 3'd0, 1'b1, pa, pd, "R9");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mMem[i] = 16'd0;
    repeat (3) @(negedge clk);
    compareAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compareAll("R1");

    preload(11'd0, 16'h1805);
    preload(11'd5, 16'h8123);

    uop(3'd6, 3'd0, 3'd0, "R2");   // AR <- PC
    uop(3'd0, 3'd4, 3'd5, "R7");   // read + PC increment: DR=1805, opcode 3
    uop(3'd5, 3'd0, 3'd0, "R2");   // AR <- DR low = 5
    uop(3'd0, 3'd4, 3'd0, "R3");   // DR = 8123, indirect bit set
    uop(3'd4, 3'd5, 3'd0, "R6");   // swap: AC=8123, DR=0
    uop(3'd0, 3'd6, 3'd0, "R3");   // DR=1
    uop(3'd4, 3'd5, 3'd0, "R6");   // swap: AC=1, DR=8123
    uop(3'd1, 3'd0, 3'd0, "R2");   // AC=8124
    uop(3'd0, 3'd1, 3'd0, "R3");   // AC=1
    uop(3'd0, 3'd2, 3'd0, "R3");   // OR
    uop(3'd0, 3'd3, 3'd0, "R3");   // AND
    uop(3'd0, 3'd0, 3'd1, "R4");   // XOR -> 0
    uop(3'd0, 3'd0, 3'd2, "R4");   // COM -> FFFF
    uop(3'd3, 3'd0, 3'd0, "R5");   // wrap to 0
    uop(3'd0, 3'd0, 3'd2, "R4");   // FFFF
    uop(3'd0, 3'd0, 3'd3, "R5");   // FFFE
    uop(3'd0, 3'd0, 3'd4, "R5");   // 7FFF, zero in at top
    uop(3'd0, 3'd1, 3'd0, "R5");   // 7FFF - 8123 wraps
    uop(3'd0, 3'd0, 3'd7, "R4");   // reserved code
    uop(3'd0, 3'd0, 3'd0, "R10");
    uop(3'd0, 3'd7, 3'd5, "R3");   // DR low <- PC, PC+1
    uop(3'd0, 3'd0, 3'd6, "R4");   // PC <- AR
    uop(3'd7, 3'd6, 3'd0, "R7");   // write old DR, DR+1
    uop(3'd0, 3'd4, 3'd0, "R7");   // read back old DR
    uop(3'd2, 3'd0, 3'd0, "R2");   // clear AC
    uop(3'd0, 3'd6, 3'd0, "R3");   // DR+1 so a write would differ
    step(3'd7, 3'd0, 3'd0, 1'b1, 11'd9, 16'h1234, "R9");  // write ignored
    uop(3'd0, 3'd4, 3'd0, "R9");   // mem[5] unchanged
    uop(3'd0, 3'd0, 3'd0, "R10");
    for (int k = 0; k < 4; k++) uop(3'd3, 3'd6, 3'd5, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule